// File: doc/BRIEF.md
# Quasi-Resonant Valley Selector

This block decides when a flyback power switch may be turned back on. During each off-time it watches a synchronised zero-crossing comparator bit that is high while the auxiliary winding voltage sits below the valley threshold. Every entry into that state is counted as one valley of the resonant ringing. When the ringing is too damped to cross the threshold, an internal timeout stands in for the missing valleys. When the count reaches the chosen valley, the block raises a one-clock turn-on request.

The valley used depends on two inputs. One is a debounced line-range flag, taken from a raw high-line comparator bit. The other is an 8-bit current set-point in percent. These are combined through a hysteresis table with six set-point bands and two line ranges. Lower set-points and high line move the switch to later valleys, which limits the switching frequency. Hysteresis on both the line range and the set-point keeps the block locked on a valley until one of them crosses its threshold. A new choice takes effect only when the next off-time begins.

All time constants are parameters counted in system-clock cycles.

Top module: `qr_valley_sel`

## Requirements
- R1: After reset, turn_on is 0, valley_idx is 1 and high_line is 0.
- R2: A valley event occurs when zcd_low is 0 on one clock edge and 1 on the next, and blanking is over. On the event that reaches the selected valley, turn_on is 1 for exactly one cycle, in the cycle after that edge. No further pulse follows in the same off-time.
- R3: For the first BLANK_CYC clock edges after an off-time starts, zcd_low transitions are ignored. An off-time starts at the first edge that samples gate_on at 0 after an edge that sampled it at 1.
- R4: Suppose zcd_low stays 1 for TIMEOUT_CYC consecutive enabled edges, counted from the last zcd_low transition, the last substitute event, or the end of blanking. A substitute valley event then occurs, and this repeats while zcd_low stays 1.
- R5: high_line takes the value of line_raw only after line_raw has differed from it on LINE_CYC consecutive clock edges. A shorter disagreement leaves high_line unchanged.
- R6: At full set-point, the selected valley is 1 when high_line is 0 and 2 when high_line is 1.
- R7: There are six set-point bands, numbered 0 to 5. Band 0 is full set-point. In band order, the selected valley is 1, 2, 4, 7, 11, 13 at low line and 2, 3, 5, 8, 12, 15 at high line. The band moves one step later when setpoint is below 75, 50, 30, 15 or 6, the threshold of the current band 0..4.
- R8: The band moves one step earlier when setpoint is at or above the return threshold for the current band 1..5: 78, 53, 33, 20 and 8. Between the two thresholds the band holds.
- R9: valley_idx shows the valley selected for the current off-time. It is loaded only at the start of an off-time and holds while the off-time runs.
- R10: If gate_on goes to 1 before the selected valley is reached, the count is discarded and no turn_on is produced for that off-time. The next off-time counts again from zero. turn_on is never 1 in a cycle that follows an edge that sampled gate_on at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zcd_low | input | 1 | Synchronised comparator bit, 1 while the winding voltage is below the valley threshold |
| gate_on | input | 1 | Gate-drive state, 1 during the on-time |
| line_raw | input | 1 | Raw high-line comparator bit |
| setpoint | input | 8 | Current set-point in percent |
| turn_on | output | 1 | One-cycle request to start the next on-time |
| valley_idx | output | 4 | Valley number selected for the current off-time |
| high_line | output | 1 | Filtered line-range flag |

## Verification
The hardest conditions to reach are those that combine the timeout with a late valley. One example is a fully damped off-time at the deepest bands, where eleven or more substitute events must fire back to back. Another is a single real valley followed by silence, where the timeout must restart from that transition. The stimulus holds zcd_low high through whole off-times after stepping the set-point down through every band. It also changes the set-point in the middle of an off-time, and raises gate_on before the target valley is reached. A behavioural model checks the exact pulse cycle against every output on every clock.

// File: rtl/qrv_pkg.sv
package qrv_pkg;
  localparam int PCT_W  = 8;
  localparam int VIDX_W = 4;
  localparam int NBANDS = 6;

  typedef logic [2:0] band_t;

  // valley number for a band and line range
  function automatic logic [VIDX_W-1:0] valley_of(input logic hl, input band_t b);
    logic [VIDX_W-1:0] v;
    case (b)
      3'd0:    v = hl ? 4'd2  : 4'd1;
      3'd1:    v = hl ? 4'd3  : 4'd2;
      3'd2:    v = hl ? 4'd5  : 4'd4;
      3'd3:    v = hl ? 4'd8  : 4'd7;
      3'd4:    v = hl ? 4'd12 : 4'd11;
      default: v = hl ? 4'd15 : 4'd13;
    endcase
    return v;
  endfunction

  // below this the band steps later
  function automatic logic [PCT_W-1:0] later_thr(input band_t b);
    logic [PCT_W-1:0] t;
    case (b)
      3'd0:    t = 8'd75;
      3'd1:    t = 8'd50;
      3'd2:    t = 8'd30;
      3'd3:    t = 8'd15;
      3'd4:    t = 8'd6;
      default: t = 8'd0;
    endcase
    return t;
  endfunction

  // at or above this the band steps earlier
  function automatic logic [PCT_W-1:0] earlier_thr(input band_t b);
    logic [PCT_W-1:0] t;
    case (b)
      3'd1:    t = 8'd78;
      3'd2:    t = 8'd53;
      3'd3:    t = 8'd33;
      3'd4:    t = 8'd20;
      3'd5:    t = 8'd8;
      default: t = 8'd255;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/qrv_line_filter.sv
module qrv_line_filter #(
  parameter int LINE_CYC = 3125000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic flag
);
  localparam int CW = $clog2(LINE_CYC + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      run_q <= '0;
    end else if (raw == flag) begin
      run_q <= '0;
    end else if (run_q == CW'(LINE_CYC - 1)) begin
      flag  <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/qrv_band_sel.sv
module qrv_band_sel
  import qrv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PCT_W-1:0] setpoint,
  output band_t            band
);
  localparam band_t LAST = band_t'(NBANDS - 1);

  // one hysteresis step per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      band <= '0;
    end else if (band < LAST && setpoint < later_thr(band)) begin
      band <= band + 3'd1;
    end else if (band != '0 && setpoint >= earlier_thr(band)) begin
      band <= band - 3'd1;
    end
  end
endmodule

// File: rtl/qrv_valley_track.sv
module qrv_valley_track
  import qrv_pkg::*;
#(
  parameter int BLANK_CYC   = 375,
  parameter int TIMEOUT_CYC = 813
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_on,
  input  logic              zcd_low,
  input  logic [VIDX_W-1:0] sel_valley,
  output logic              turn_on,
  output logic [VIDX_W-1:0] valley_idx
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic              gate_q, zcd_q, armed;
  logic [BW-1:0]     blank_left;
  logic [TW-1:0]     quiet_cnt;
  logic [VIDX_W-1:0] seen;
  logic              off_start, live, dip, sub_evt, evt, hit;

  always_comb begin
    off_start = gate_q & ~gate_on;
    live      = armed & (blank_left == '0);
    dip       = zcd_low & ~zcd_q;
    sub_evt   = live & zcd_low & zcd_q & (quiet_cnt == TW'(TIMEOUT_CYC - 1));
    evt       = live & ~gate_on & (dip | sub_evt);
    hit       = evt & ((seen + 4'd1) == valley_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q     <= 1'b0;
      zcd_q      <= 1'b0;
      armed      <= 1'b0;
      blank_left <= '0;
      seen       <= '0;
      valley_idx <= 4'd1;
      turn_on    <= 1'b0;
    end else begin
      gate_q  <= gate_on;
      zcd_q   <= zcd_low;
      turn_on <= hit;
      if (gate_on) begin
        armed <= 1'b0;
      end else if (off_start) begin
        armed      <= 1'b1;
        blank_left <= BW'(BLANK_CYC);
        seen       <= '0;
        valley_idx <= sel_valley;
      end else begin
        if (armed && blank_left != '0) blank_left <= blank_left - 1'b1;
        if (evt) seen <= seen + 4'd1;
        if (hit) armed <= 1'b0;
      end
    end
  end

  // quiet-time counter for substitute valleys
  always_ff @(posedge clk) begin
    if (rst || !live || (zcd_low != zcd_q) || sub_evt || !zcd_low) begin
      quiet_cnt <= '0;
    end else begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qr_valley_sel.sv
module qr_valley_sel
  import qrv_pkg::*;
#(
  parameter int BLANK_CYC   = 375,
  parameter int TIMEOUT_CYC = 813,
  parameter int LINE_CYC    = 3125000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        zcd_low,
  input  logic        gate_on,
  input  logic        line_raw,
  input  logic [7:0]  setpoint,
  output logic        turn_on,
  output logic [3:0]  valley_idx,
  output logic        high_line
);
  band_t             band;
  logic [VIDX_W-1:0] sel_valley;

  qrv_line_filter #(.LINE_CYC(LINE_CYC)) u_line (
    .clk(clk), .rst(rst), .raw(line_raw), .flag(high_line)
  );

  qrv_band_sel u_band (
    .clk(clk), .rst(rst), .setpoint(setpoint), .band(band)
  );

  assign sel_valley = valley_of(high_line, band);

  qrv_valley_track #(.BLANK_CYC(BLANK_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_track (
    .clk(clk), .rst(rst), .gate_on(gate_on), .zcd_low(zcd_low),
    .sel_valley(sel_valley), .turn_on(turn_on), .valley_idx(valley_idx)
  );
endmodule

// File: rtl/qr_valley_sel_chk.sv
module qr_valley_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       gate_on,
  input logic       line_raw,
  input logic       turn_on,
  input logic [3:0] valley_idx,
  input logic       high_line
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!turn_on && valley_idx == 4'd1 && !high_line));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    turn_on |=> !turn_on);

  assert_no_pulse_gate_R10: assert property (@(posedge clk) disable iff (rst)
    turn_on |-> !$past(gate_on));

  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(gate_on) && !$past(gate_on, 2)) |-> $stable(valley_idx));

  assert_line_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(high_line) |-> (high_line == $past(line_raw)));

  always @(posedge clk) begin
    if (!rst) begin
      assert_idx_legal_R7: assert (valley_idx inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
        4'd7, 4'd8, 4'd11, 4'd12, 4'd13, 4'd15})
        else $error("valley_idx %0d outside table", valley_idx);
    end
  end
endmodule

bind qr_valley_sel qr_valley_sel_chk u_chk (
  .clk(clk), .rst(rst), .gate_on(gate_on), .line_raw(line_raw),
  .turn_on(turn_on), .valley_idx(valley_idx), .high_line(high_line)
);

// File: tb/qr_valley_sel_bench.sv
module qr_valley_sel_bench;
  localparam int B  = 6;
  localparam int TO = 20;
  localparam int LN = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zcd_low = 1'b0;
  logic       gate_on = 1'b0;
  logic       line_raw = 1'b0;
  logic [7:0] setpoint = 8'd100;
  logic       turn_on;
  logic [3:0] valley_idx;
  logic       high_line;

  always #4 clk = ~clk;

  qr_valley_sel #(.BLANK_CYC(B), .TIMEOUT_CYC(TO), .LINE_CYC(LN)) u_qr_valley_sel (
    .clk(clk), .rst(rst), .zcd_low(zcd_low), .gate_on(gate_on), .line_raw(line_raw),
    .setpoint(setpoint), .turn_on(turn_on), .valley_idx(valley_idx), .high_line(high_line)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int low_tab[6]  = '{1, 2, 4, 7, 11, 13};
  int high_tab[6] = '{2, 3, 5, 8, 12, 15};
  int down_tab[5] = '{75, 50, 30, 15, 6};
  int up_tab[5]   = '{78, 53, 33, 20, 8};
  int m_gate, m_zcd, m_arm, m_since, m_quiet, m_cnt, m_tgt, m_pulse, m_band, m_line, m_run;
  int g, z, en, ev, te, start;

  always @(posedge clk) begin
    if (rst) begin
      m_gate = 0; m_zcd = 0; m_arm = 0; m_since = 0; m_quiet = 0; m_cnt = 0;
      m_tgt = 1; m_pulse = 0; m_band = 0; m_line = 0; m_run = 0;
    end else begin
      g = gate_on; z = zcd_low;
      start = (m_gate == 1 && g == 0);
      if (!start && m_since < 1000000) m_since++;
      en = (m_arm == 1 && m_since > B);
      te = (en && z == 1 && m_zcd == 1 && m_quiet == TO - 1);
      ev = (en && g == 0 && ((z == 1 && m_zcd == 0) || te));
      m_pulse = (ev && m_cnt + 1 == m_tgt);
      if (!en || z != m_zcd || te || z == 0) m_quiet = 0; else m_quiet++;
      if (g == 1) m_arm = 0;
      else if (start) begin
        m_arm = 1; m_since = 0; m_cnt = 0;
        m_tgt = m_line ? high_tab[m_band] : low_tab[m_band];
      end else begin
        if (ev) m_cnt++;
        if (m_pulse) m_arm = 0;
      end
      m_gate = g; m_zcd = z;
      if (m_band < 5 && setpoint < down_tab[m_band]) m_band++;
      else if (m_band > 0 && setpoint >= up_tab[m_band-1]) m_band--;
      if (line_raw == m_line) m_run = 0;
      else begin
        m_run++;
        if (m_run == LN) begin m_line = line_raw; m_run = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(turn_on == m_pulse, "R2 model turn_on", turn_on, m_pulse);
      chk(valley_idx == m_tgt, "R9 model valley_idx", valley_idx, m_tgt);
      chk(high_line == m_line, "R5 model high_line", high_line, m_line);
    end
  end

  // mode 0 ringing, 1 damped, 2 blank glitch, 3 one valley then silence
  task automatic run_off(input int mode, input int max_k, output int first_k, output int npulse);
    gate_on = 1'b1; zcd_low = 1'b0;
    repeat (8) @(negedge clk);
    zcd_low = (mode == 1); gate_on = 1'b0;
    first_k = -1; npulse = 0;
    for (int k = 0; k < max_k; k++) begin
      @(negedge clk);
      if (turn_on) begin
        npulse++;
        if (first_k < 0) first_k = k;
      end
      case (mode)
        0:       zcd_low = ((k % 10) >= 5);
        1:       zcd_low = 1'b1;
        2:       zcd_low = ((k >= 2 && k < 4) || k >= 12);
        default: zcd_low = (k >= 10);
      endcase
    end
    gate_on = 1'b1; zcd_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sp(input int sp);
    setpoint = 8'(sp);
    repeat (12) @(negedge clk);
  endtask

  task automatic set_line(input bit v);
    line_raw = v;
    repeat (LN + 4) @(negedge clk);
  endtask

  int fk, np, kk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    gate_on = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(turn_on == 1'b0, "R1 turn_on", turn_on, 0);
    chk(valley_idx == 4'd1, "R1 valley_idx", valley_idx, 1);
    chk(high_line == 1'b0, "R1 high_line", high_line, 0);
    repeat (4) @(negedge clk);

    // R6 full set-point low line, R2 pulse on first valley
    run_off(0, 60, fk, np);
    chk(valley_idx == 4'd1, "R6 low line valley", valley_idx, 1);
    chk(fk == 16, "R2 pulse cycle", fk, 16);
    chk(np == 1, "R2 single pulse", np, 1);

    // R3 glitch inside blanking ignored
    run_off(2, 40, fk, np);
    chk(fk == 13, "R3 blanked edge", fk, 13);

    // R4 one valley then substitute
    set_sp(60);
    run_off(3, 60, fk, np);
    chk(valley_idx == 4'd2, "R7 band1 low line", valley_idx, 2);
    chk(fk == 31, "R4 substitute after real valley", fk, 31);

    // R5 short glitch then full hold
    line_raw = 1'b1;
    repeat (LN - 10) @(negedge clk);
    line_raw = 1'b0;
    repeat (4) @(negedge clk);
    chk(high_line == 1'b0, "R5 short glitch", high_line, 0);
    line_raw = 1'b1;
    kk = 0;
    for (int k = 1; k <= LN + 10; k++) begin
      @(negedge clk);
      if (high_line && kk == 0) kk = k;
    end
    chk(kk == LN, "R5 hold length", kk, LN);

    // R6/R7 high line sweep
    begin
      int sps[6] = '{100, 70, 45, 25, 10, 5};
      for (int i = 0; i < 6; i++) begin
        set_sp(sps[i]);
        run_off(0, 170, fk, np);
        chk(valley_idx == 4'(high_tab[i]), "R7 high line valley", valley_idx, high_tab[i]);
        chk(fk == 6 + 10 * high_tab[i], "R2 high line pulse", fk, 6 + 10 * high_tab[i]);
        chk(np == 1, "R2 one pulse", np, 1);
      end
      set_line(1'b0);
      for (int i = 0; i < 6; i++) begin
        set_sp(sps[i]);
        run_off(0, 170, fk, np);
        chk(valley_idx == 4'(low_tab[i]), "R7 low line valley", valley_idx, low_tab[i]);
      end
    end

    // R8 hysteresis around first band
    set_sp(74);  run_off(0, 40, fk, np);
    chk(valley_idx == 4'd2, "R8 below 75", valley_idx, 2);
    set_sp(77);  run_off(0, 40, fk, np);
    chk(valley_idx == 4'd2, "R8 hold at 77", valley_idx, 2);
    set_sp(78);  run_off(0, 40, fk, np);
    chk(valley_idx == 4'd1, "R8 back at 78", valley_idx, 1);
    set_sp(76);  run_off(0, 40, fk, np);
    chk(valley_idx == 4'd1, "R8 hold at 76", valley_idx, 1);

    // R9 change during off-time
    set_sp(100);
    gate_on = 1'b1; repeat (8) @(negedge clk);
    gate_on = 1'b0; repeat (3) @(negedge clk);
    setpoint = 8'd10;
    repeat (20) @(negedge clk);
    chk(valley_idx == 4'd1, "R9 held mid off-time", valley_idx, 1);
    run_off(1, 260, fk, np);
    chk(valley_idx == 4'd11, "R9 new valley next off-time", valley_idx, 11);
    chk(fk == B + 11 * TO, "R4 damped substitute train", fk, B + 11 * TO);

    // R10 abort before target
    run_off(0, 60, fk, np);
    chk(np == 0, "R10 aborted off-time", np, 0);
    run_off(0, 130, fk, np);
    chk(fk == 116, "R10 count restarts", fk, 116);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule